// File: doc/BRIEF.md
# Phase Detector with Lock Indicator

This block compares two divided pulse trains, a reference train and a VCO train, and produces the control for two charge pumps plus a lock flag. A rising edge on either train arms a pending flag for that input. When the other input's edge arrives, both flags clear together. Each error pulse therefore lasts as many sampling-clock cycles as separate the two edges. While the reference flag is pending the reference leads. While the VCO flag is pending the reference lags.

Each charge-pump control is a tri-state encoding made of a drive-enable bit and a level bit. One control serves an active loop filter and the other a passive loop filter, and the two have opposite sense for the same phase error. Both sit at high impedance when the phases agree. The lock flag rises after a run of consecutive comparisons whose error pulse stayed within a small tolerance. It drops at once when any error pulse grows past that tolerance.

Both pulse inputs come from dividers clocked in the same domain as the sampling clock and are treated as synchronous, plain control pins. No data stream crosses the block, so it has no valid/ready interface and never applies back-pressure.

Top module: `phase_lock_detector`

## Requirements
- R1: Reset (rst_n low, asynchronous) forces both enables and both levels to 0 and lock_o to 0. Whenever an enable is 0 its level bit is 0. Encoding: en=0 means high impedance, en=1 with lvl=0 means negative pulse, en=1 with lvl=1 means positive pulse.
- R2: A reference rising edge sampled with no VCO edge and no pulse pending makes the reference lead. From the following cycle act_en=1, act_lvl=0, pas_en=1 and pas_lvl=1, until a VCO edge is sampled.
- R3: A VCO rising edge sampled with no reference edge and no pulse pending makes the reference lag. From the following cycle act_en=1, act_lvl=1, pas_en=1 and pas_lvl=0, until a reference edge is sampled.
- R4: The edge of the lagging input clears the pending state, and both controls return to high impedance on the next cycle. The error pulse therefore lasts exactly the edge separation in clock cycles. Edges of both inputs sampled on the same cycle produce no pulse.
- R5: A repeated edge of the leading input while its pulse is pending has no effect. The pulse keeps its polarity and still ends on the lagging input's edge.
- R6: lock_o rises on the cycle after the 8th consecutive comparison whose error width is at most 2 cycles. A simultaneous-edge comparison counts as width 0. lock_o then stays high while errors stay within tolerance.
- R7: Once a pending error pulse reaches 3 cycles, lock_o is 0 on the next cycle, and the run of good comparisons restarts from zero.
- R8: pas_en always equals act_en, and while enabled pas_lvl is the inverse of act_lvl.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_pulse_i | input | 1 | Divided reference pulse train |
| vco_pulse_i | input | 1 | Divided VCO pulse train |
| act_en_o | output | 1 | Active-filter charge pump drive enable (0 = high impedance) |
| act_lvl_o | output | 1 | Active-filter charge pump level (1 = positive pulse) |
| pas_en_o | output | 1 | Passive-filter charge pump drive enable (0 = high impedance) |
| pas_lvl_o | output | 1 | Passive-filter charge pump level (1 = positive pulse) |
| lock_o | output | 1 | Lock flag, low while unlocked |

## Verification
The assertions check on every cycle the following properties:
- the opposite sense of the two controls and the low level in high impedance;
- the start of a lead or lag pulse one cycle after a lone edge;
- the clearing on the lagging edge and the holding of a pending pulse against repeated leading edges;
- lock falling after an oversized error and lock rising only on a completed comparison.

Three behaviours depend on a history of many comparisons, so only the bench scenarios can show them:
- the exact pulse widths;
- the count of eight good comparisons before lock;
- the boundary between a 2-cycle and a 3-cycle error.

The bench shows these with a behavioural model compared on every clock.

// File: rtl/pd_pkg.sv
package pd_pkg;
  typedef enum logic [1:0] {
    PD_IDLE     = 2'b00,
    PD_REF_LEAD = 2'b01,
    PD_VCO_LEAD = 2'b10
  } pd_state_t;

  localparam int PD_NUM_CH = 2;
  localparam int PD_CH_REF = 0;
  localparam int PD_CH_VCO = 1;
endpackage

// File: rtl/pd_edge_rise.sv
module pd_edge_rise (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sig_i;
  end

  assign rise_o = sig_i & ~prev_q;
endmodule

// File: rtl/pd_pfd_core.sv
module pd_pfd_core
  import pd_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ref_rise_i,
  input  logic      vco_rise_i,
  output pd_state_t state_o,
  output logic      active_o,
  output logic      cmp_done_o
);
  logic up_q, dn_q;
  logic up_set, dn_set, both_set;

  // Each edge arms its own flag; both armed means the comparison ends.
  assign up_set   = up_q | ref_rise_i;
  assign dn_set   = dn_q | vco_rise_i;
  assign both_set = up_set & dn_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else begin
      up_q <= up_set & ~both_set;
      dn_q <= dn_set & ~both_set;
    end
  end

  always_comb begin
    if (up_q)      state_o = PD_REF_LEAD;
    else if (dn_q) state_o = PD_VCO_LEAD;
    else           state_o = PD_IDLE;
  end

  assign active_o   = up_q | dn_q;
  assign cmp_done_o = both_set;

  // R4: lagging edge ends a pending pulse
  p_lag_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((up_q && vco_rise_i) || (dn_q && ref_rise_i)) |=> (!up_q && !dn_q));

  // R4: coincident edges from idle leave no pulse
  p_coincident_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!up_q && !dn_q && ref_rise_i && vco_rise_i) |=> (!up_q && !dn_q));

  // R5: repeated leading edges do not disturb a pending pulse
  p_lead_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q && !vco_rise_i) |=> up_q);
endmodule

// File: rtl/pd_lock_filter.sv
module pd_lock_filter #(
  parameter int TOL_W  = 2,
  parameter int LOCK_N = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active_i,
  input  logic cmp_done_i,
  output logic lock_o
);
  localparam int CNT_W  = $clog2(TOL_W + 2);
  localparam int GOOD_W = $clog2(LOCK_N + 1);
  localparam logic [CNT_W-1:0]  TOL_V  = CNT_W'(TOL_W);
  localparam logic [CNT_W-1:0]  SAT_V  = CNT_W'(TOL_W + 1);
  localparam logic [GOOD_W-1:0] LOCK_V = GOOD_W'(LOCK_N);

  logic [CNT_W-1:0]  cnt_q, width_run;
  logic [GOOD_W-1:0] good_q;
  logic              lock_q, wide;

  // Running error width including the current cycle, saturating.
  always_comb begin
    if (active_i && cnt_q != SAT_V) width_run = cnt_q + 1'b1;
    else                            width_run = cnt_q;
  end
  assign wide = width_run > TOL_V;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (cmp_done_i) cnt_q <= '0;
    else if (active_i)   cnt_q <= width_run;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      good_q <= '0;
      lock_q <= 1'b0;
    end else if (wide) begin
      good_q <= '0;
      lock_q <= 1'b0;
    end else if (cmp_done_i) begin
      if (good_q != LOCK_V) good_q <= good_q + 1'b1;
      lock_q <= lock_q | ((good_q + 1'b1) >= LOCK_V);
    end
  end

  assign lock_o = lock_q;

  // R7: oversized error drops lock on the next cycle
  p_wide_unlocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wide |=> !lock_q);

  // R6: lock only rises right after a completed comparison
  p_lock_rise_on_cmp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_q) |-> $past(cmp_done_i));

  // R6: lock persists while errors stay in tolerance
  p_lock_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && !wide) |=> lock_q);
endmodule

// File: rtl/phase_lock_detector.sv
module phase_lock_detector
  import pd_pkg::*;
#(
  parameter int TOL_W  = 2,
  parameter int LOCK_N = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_pulse_i,
  input  logic vco_pulse_i,
  output logic act_en_o,
  output logic act_lvl_o,
  output logic pas_en_o,
  output logic pas_lvl_o,
  output logic lock_o
);
  logic [PD_NUM_CH-1:0] pulse_in, rise;
  pd_state_t            state;
  logic                 active, cmp_done;

  assign pulse_in[PD_CH_REF] = ref_pulse_i;
  assign pulse_in[PD_CH_VCO] = vco_pulse_i;

  for (genvar ch = 0; ch < PD_NUM_CH; ch++) begin : g_edge
    pd_edge_rise u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .sig_i  (pulse_in[ch]),
      .rise_o (rise[ch])
    );
  end

  pd_pfd_core u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .ref_rise_i (rise[PD_CH_REF]),
    .vco_rise_i (rise[PD_CH_VCO]),
    .state_o    (state),
    .active_o   (active),
    .cmp_done_o (cmp_done)
  );

  pd_lock_filter #(.TOL_W(TOL_W), .LOCK_N(LOCK_N)) u_lock (
    .clk        (clk),
    .rst_n      (rst_n),
    .active_i   (active),
    .cmp_done_i (cmp_done),
    .lock_o     (lock_o)
  );

  // Reference leading: active sinks (negative), passive sources (positive).
  assign act_en_o  = (state != PD_IDLE);
  assign pas_en_o  = (state != PD_IDLE);
  assign act_lvl_o = (state == PD_VCO_LEAD);
  assign pas_lvl_o = (state == PD_REF_LEAD);

  // R8: controls share enable, opposite level while driving
  p_pair_opposite_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (act_en_o == pas_en_o) && (!act_en_o || (act_lvl_o != pas_lvl_o)));

  // R1: high impedance carries a low level bit
  p_hiz_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !act_en_o |-> (!act_lvl_o && !pas_lvl_o));

  // R2: lone reference edge from idle gives a negative active pulse
  p_ref_lead_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_en_o && rise[PD_CH_REF] && !rise[PD_CH_VCO])
      |=> (act_en_o && !act_lvl_o && pas_lvl_o));

  // R3: lone VCO edge from idle gives a positive active pulse
  p_vco_lead_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_en_o && rise[PD_CH_VCO] && !rise[PD_CH_REF])
      |=> (act_en_o && act_lvl_o && !pas_lvl_o));

  // R1: reset state
  always @(posedge clk) begin
    if (!rst_n) begin
      a_reset_quiet_r1: assert (!act_en_o && !pas_en_o && !lock_o);
    end
  end
endmodule

// File: tb/phase_lock_detector_tb.sv
module phase_lock_detector_tb;
  localparam int TOL = 2;
  localparam int NLOCK = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_p = 1'b0, vco_p = 1'b0;
  logic act_en, act_lvl, pas_en, pas_lvl, lock;

  int tests = 0, fails = 0;
  bit done = 0;

  // behavioural model state
  int  m_lead = 0;   // +1 reference leads, -1 VCO leads, 0 aligned
  int  m_len  = 0;
  int  m_good = 0;
  bit  m_lock = 0;
  bit  m_ref_prev = 0, m_vco_prev = 0;

  always #2 clk = ~clk;

  phase_lock_detector #(.TOL_W(TOL), .LOCK_N(NLOCK)) u_dut (
    .clk(clk), .rst_n(rst_n), .ref_pulse_i(ref_p), .vco_pulse_i(vco_p),
    .act_en_o(act_en), .act_lvl_o(act_lvl), .pas_en_o(pas_en),
    .pas_lvl_o(pas_lvl), .lock_o(lock));

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic m_drop();
    m_good = 0;
    m_lock = 0;
  endtask

  task automatic m_complete(input int w);
    if (w > TOL) m_drop();
    else begin
      m_good++;
      if (m_good >= NLOCK) m_lock = 1;
    end
  endtask

  task automatic m_step(input bit r, input bit v);
    bit rr, vr, lag;
    rr = r && !m_ref_prev;
    vr = v && !m_vco_prev;
    m_ref_prev = r;
    m_vco_prev = v;
    if (m_lead == 0) begin
      if (rr && vr) m_complete(0);
      else if (rr) begin m_lead = 1;  m_len = 0; end
      else if (vr) begin m_lead = -1; m_len = 0; end
    end else begin
      lag = (m_lead == 1) ? vr : rr;
      m_len++;
      if (lag) begin
        m_complete(m_len);
        m_lead = 0;
      end else if (m_len > TOL) m_drop();
    end
  endtask

  // One clock: drive at negedge, model at posedge, compare after the edge.
  task automatic cyc(input bit r, input bit v);
    @(negedge clk);
    ref_p = r;
    vco_p = v;
    @(posedge clk);
    m_step(r, v);
    #1;
    chk("R2 R3 R4 act_en", act_en, (m_lead != 0));
    chk("R2 R3 act_lvl", act_lvl, (m_lead == -1));
    chk("R8 pas_en", pas_en, (m_lead != 0));
    chk("R2 R3 pas_lvl", pas_lvl, (m_lead == 1));
    chk("R6 R7 lock", lock, m_lock);
  endtask

  // One comparison window; optional extra reference edge at dr2 (-1 none).
  task automatic pair(input int dr, input int dv, input int dr2,
                      output int act_cycles, output int neg_cycles);
    int n;
    n = ((dr > dv) ? dr : dv) + 3;
    if (dr2 + 3 > n) n = dr2 + 3;
    act_cycles = 0;
    neg_cycles = 0;
    for (int i = 0; i < n; i++) begin
      cyc((i == dr) || (i == dr2), (i == dv));
      if (act_en) act_cycles++;
      if (act_en && !act_lvl) neg_cycles++;
    end
  endtask

  initial begin
    int a, ng;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk);
    end
    #1;
    chk("R1 reset act_en", act_en, 0);
    chk("R1 reset pas_en", pas_en, 0);
    chk("R1 reset levels", {act_lvl, pas_lvl}, 0);
    chk("R1 reset lock", lock, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R2: reference leads by 1, seven comparisons: not yet locked
    for (int k = 0; k < 7; k++) pair(1, 2, -1, a, ng);
    chk("R2 lead-1 width", a, 1);
    chk("R2 negative active pulse", ng, 1);
    chk("R6 no lock after 7", lock, 0);
    pair(1, 2, -1, a, ng);
    chk("R6 lock after 8th", lock, 1);

    // R6 boundary: width 2 keeps lock
    pair(1, 3, -1, a, ng);
    chk("R4 width 2", a, 2);
    chk("R6 lock kept at width 2", lock, 1);

    // R7: width 3 drops lock
    pair(1, 4, -1, a, ng);
    chk("R4 width 3", a, 3);
    chk("R7 lock dropped", lock, 0);

    // R3: VCO leads by 2, eight times relocks
    for (int k = 0; k < 8; k++) pair(3, 1, -1, a, ng);
    chk("R3 lag width", a, 2);
    chk("R3 no negative active", ng, 0);
    chk("R6 relock via lag", lock, 1);

    // R4: coincident edges give no pulse
    pair(2, 2, -1, a, ng);
    chk("R4 coincident no pulse", a, 0);
    chk("R6 coincident counts good", lock, 1);

    // R5: repeated reference edge during pending pulse
    pair(0, 6, 3, a, ng);
    chk("R5 pulse spans to lag edge", a, 6);
    chk("R5 polarity kept", ng, 6);
    chk("R7 long pulse unlocks", lock, 0);

    // Long lead mid-pulse and frequency mismatch mix
    pair(1, 12, -1, a, ng);
    chk("R4 width 11", a, 11);
    for (int k = 0; k < 5; k++) pair(1, 1, -1, a, ng);
    chk("R6 partial run stays unlocked", lock, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule